// File: doc/BRIEF.md
# Password-protected watchdog timer

This block is a memory-mapped watchdog for a system-on-chip. Software reaches it through a single-cycle register port with an address, write data, a write strobe and a combinational read-data path. Two offsets are decoded: a write-only control word and a read-only status word. A clock prescaler with four selectable ratios drives a 16-bit down-counter. When that counter runs out, the block raises a one-cycle reset request for the system reset controller. It also sets a sticky flag that names the watchdog as the cause of the reset.

The control word is guarded by a two-step key. The first write must be an exact opening word. The next bus write must carry the configuration key together with the new enable, power, divider and reload fields. Any other write cancels the attempt. Running the full two-step sequence again reloads the counter, and software uses this as its keep-alive. A configuration with the enable bit clear stops the count.

Two resets exist. The ordinary synchronous reset returns the timer to its idle state and leaves the cause flag alone. The power-on reset also clears the cause flag.

Top module: `pwd_watchdog`

## Requirements
- R1: While `rst_i` or `por_i` is high at a rising edge, the timer is cleared: enable 0, power 0, divider 0, count 0, no reset request, key state locked. `por_i` also clears the cause flag. `rst_i` alone leaves the cause flag unchanged.
- R2: A write of exactly 0x00BE0000 to offset 0x0 arms the key. If the next bus write goes to offset 0x0 and has 0xDC in bits 23:16, it loads the configuration from that word: bit 31 enable, bits 27:26 power, bits 25:24 divider select, bits 15:0 reload. The counter takes the reload value, the prescaler restarts, and the key state returns to locked.
- R3: The following writes change no configuration and no count, and leave the key locked: a write to offset 0x0 while locked that is not exactly 0x00BE0000; any write while armed that does not meet R2 (another opening word, a write to offset 0x8, a write without 0xDC in bits 23:16); any write to offset 0x8.
- R4: A configuration with bit 31 clear stops the count, and the count then holds the loaded reload value. The configuring word 0x00DC0000 turns the timer off, and the status word then reads zero.
- R5: Divider select 0, 1, 2 and 3 makes the counter step once every 1, 64, 4096 and 262144 clock cycles while enabled.
- R6: A read at offset 0x8 returns, in the same cycle, bit 31 enable, bits 27:26 power, bits 25:24 divider select and bits 15:0 the current count, with all other bits zero. A read at any other offset returns zero.
- R7: A counter step taken while the count is zero is an expiry. It raises `wdt_req_o` for exactly one cycle, starting in the cycle after that edge, and clears the enable bit. After a configuring write with reload N and divide ratio D, the request therefore appears (N+1)*D edges after the edge that accepted the write.
- R8: An expiry sets the cause flag. The flag holds until `por_i` clears it. `cause_code_o` reads 2 while the flag is set and 0 otherwise.
- R9: Repeating the full R2 sequence with enable set reloads the count and restarts the prescaler. Regular repeats therefore keep the request from ever being raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset; keeps the cause flag |
| por_i | input | 1 | Synchronous active-high power-on reset; also clears the cause flag |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, one write per high cycle |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| wdt_req_o | output | 1 | One-cycle reset request on expiry |
| cause_flag_o | output | 1 | Sticky flag: the last reset was caused by the watchdog |
| cause_code_o | output | 3 | Reset-cause field, 2 when the watchdog is the cause |

## Verification
The status read is combinational, so it is sampled in the same cycle as the address. A configuring write shows up in the status word just after the edge that samples it. The reset request and the cause flag appear just after the ((reload+1)*ratio)-th edge that follows that one, and the request drops one edge later. The bench steps a behavioural model at every rising edge and compares all outputs 5 ns later, after the edge has settled. Its directed checks count rising edges from the accepting edge to the first sight of the request, then compare that count with the computed (N+1)*D.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 16;
    localparam int PWR_W    = 2;
    localparam int DSEL_W   = 2;
    localparam int KEY_W    = 8;
    localparam int KEY_LSB  = 16;
    localparam int EN_BIT   = 31;
    localparam int PWR_LSB  = 26;
    localparam int DSEL_LSB = 24;
    localparam int DIV_SH1  = 6;
    localparam int DIV_SH2  = 12;
    localparam int DIV_SH3  = 18;
    localparam int PRE_W    = DIV_SH3;

    localparam logic [KEY_W-1:0]  KEY_OPEN  = 8'hBE;
    localparam logic [KEY_W-1:0]  KEY_CONF  = 8'hDC;
    localparam logic [WORD_W-1:0] OPEN_WORD = WORD_W'(KEY_OPEN) << KEY_LSB;

    typedef enum logic {
        UL_LOCKED,
        UL_ARMED
    } unlock_st_t;

    typedef struct packed {
        logic              en;
        logic [PWR_W-1:0]  pwr;
        logic [DSEL_W-1:0] dsel;
        logic [CNT_W-1:0]  reload;
    } wdg_cfg_t;

    function automatic wdg_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        wdg_cfg_t c;
        c.en     = w[EN_BIT];
        c.pwr    = w[PWR_LSB +: PWR_W];
        c.dsel   = w[DSEL_LSB +: DSEL_W];
        c.reload = w[CNT_W-1:0];
        return c;
    endfunction

    function automatic logic [PRE_W-1:0] pre_mask(input logic [DSEL_W-1:0] s);
        logic [PRE_W-1:0] m;
        unique case (s)
            2'd0:    m = '0;
            2'd1:    m = PRE_W'((1 << DIV_SH1) - 1);
            2'd2:    m = PRE_W'((1 << DIV_SH2) - 1);
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(
        input logic              en,
        input logic [PWR_W-1:0]  pwr,
        input logic [DSEL_W-1:0] dsel,
        input logic [CNT_W-1:0]  cnt
    );
        logic [WORD_W-1:0] w;
        w                       = '0;
        w[EN_BIT]               = en;
        w[PWR_LSB +: PWR_W]     = pwr;
        w[DSEL_LSB +: DSEL_W]   = dsel;
        w[CNT_W-1:0]            = cnt;
        return w;
    endfunction
endpackage

// File: rtl/wdg_unlock.sv
module wdg_unlock
    import wdg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic              sel_ctrl_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              load_o,
    output wdg_cfg_t          cfg_o
);
    unlock_st_t st_q, st_d;
    logic       open_hit;
    logic       conf_hit;

    assign open_hit = sel_ctrl_i && (wdata_i == OPEN_WORD);
    assign conf_hit = sel_ctrl_i && (wdata_i[KEY_LSB +: KEY_W] == KEY_CONF);
    assign cfg_o    = cfg_from_word(wdata_i);

    always_comb begin
        st_d   = st_q;
        load_o = 1'b0;
        if (we_i) begin
            unique case (st_q)
                UL_LOCKED: st_d = open_hit ? UL_ARMED : UL_LOCKED;
                UL_ARMED: begin
                    st_d   = UL_LOCKED;
                    load_o = conf_hit;
                end
                default: st_d = UL_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= UL_LOCKED;
        else       st_q <= st_d;
    end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
    import wdg_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              restart_i,
    input  logic              run_i,
    input  logic [DSEL_W-1:0] dsel_i,
    output logic              tick_o
);
    logic [PW-1:0] pre_q;
    logic [PW-1:0] mask;

    assign mask   = PW'(pre_mask(dsel_i));
    assign tick_o = run_i && ((pre_q & mask) == mask);

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) pre_q <= '0;
        else if (run_i)         pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;

    assign cnt_o    = cnt_q;
    assign expire_o = tick_i && !load_i && (cnt_q == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i)                      cnt_q <= '0;
        else if (load_i)                cnt_q <= load_val_i;
        else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/pwd_watchdog.sv
module pwd_watchdog
    import wdg_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CTRL_OFS = 0,
    parameter int STAT_OFS = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              por_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    input  logic              bus_we_i,
    output logic [31:0]       bus_rdata_o,
    output logic              wdt_req_o,
    output logic              cause_flag_o,
    output logic [2:0]        cause_code_o
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [2:0]        CAUSE_WDT = 3'd2;

    logic              sys_rst;
    logic              sel_ctrl;
    logic              cfg_load;
    wdg_cfg_t          cfg_new;
    logic              en_q;
    logic [PWR_W-1:0]  pwr_q;
    logic [DSEL_W-1:0] dsel_q;
    logic              tick;
    logic              expire;
    logic [CNT_W-1:0]  cnt_q;
    logic              req_q;
    logic              flag_q;

    assign sys_rst  = rst_i || por_i;
    assign sel_ctrl = (bus_addr_i == CTRL_A);

    wdg_unlock u_unlock (
        .clk_i      (clk_i),
        .rst_i      (sys_rst),
        .we_i       (bus_we_i),
        .sel_ctrl_i (sel_ctrl),
        .wdata_i    (bus_wdata_i),
        .load_o     (cfg_load),
        .cfg_o      (cfg_new)
    );

    wdg_prescaler #(.PW(PRE_W)) u_pre (
        .clk_i     (clk_i),
        .rst_i     (sys_rst),
        .restart_i (cfg_load),
        .run_i     (en_q),
        .dsel_i    (dsel_q),
        .tick_o    (tick)
    );

    wdg_counter #(.W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_i      (sys_rst),
        .load_i     (cfg_load),
        .load_val_i (cfg_new.reload),
        .tick_i     (tick),
        .cnt_o      (cnt_q),
        .expire_o   (expire)
    );

    always_ff @(posedge clk_i) begin
        if (sys_rst) begin
            en_q   <= 1'b0;
            pwr_q  <= '0;
            dsel_q <= '0;
        end else if (cfg_load) begin
            en_q   <= cfg_new.en;
            pwr_q  <= cfg_new.pwr;
            dsel_q <= cfg_new.dsel;
        end else if (expire) begin
            en_q   <= 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (sys_rst) req_q <= 1'b0;
        else         req_q <= expire;
    end

    always_ff @(posedge clk_i) begin
        if (por_i)       flag_q <= 1'b0;
        else if (expire) flag_q <= 1'b1;
    end

    assign bus_rdata_o  = (bus_addr_i == STAT_A) ? pack_status(en_q, pwr_q, dsel_q, cnt_q) : '0;
    assign wdt_req_o    = req_q;
    assign cause_flag_o = flag_q;
    assign cause_code_o = flag_q ? CAUSE_WDT : 3'd0;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter int CW = 16
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          por_i,
    input logic          we_i,
    input logic          en_i,
    input logic [CW-1:0] cnt_i,
    input logic          req_i,
    input logic          flag_i
);
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
        req_i |=> !req_i); // R7
    AST_REQ_STOPS_TIMER: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
        req_i |-> !en_i); // R7
    AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
        !en_i |=> !req_i); // R7
    AST_REQ_SETS_FLAG: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
        req_i |-> flag_i); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (por_i)
        flag_i |=> flag_i); // R8
    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
        (!we_i && en_i) |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) - 1'b1)); // R5
    AST_OFF_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
        (!we_i && !en_i) |=> $stable(cnt_i)); // R4
endmodule

bind pwd_watchdog wdg_checker #(.CW(wdg_pkg::CNT_W)) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .por_i  (por_i),
    .we_i   (bus_we_i),
    .en_i   (en_q),
    .cnt_i  (cnt_q),
    .req_i  (req_q),
    .flag_i (flag_q)
);

// File: tb/pwd_watchdog_tb.sv
`timescale 1ns/1ps
module pwd_watchdog_tb_top;
    localparam int CLK_PER = 20;
    localparam int WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por = 1'b1;
    logic [3:0]  addr = 4'd8;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        req;
    logic        flag;
    logic [2:0]  code;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    pwd_watchdog dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .por_i        (por),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_we_i     (we),
        .bus_rdata_o  (rdata),
        .wdt_req_o    (req),
        .cause_flag_o (flag),
        .cause_code_o (code)
    );

    task automatic check(input bit ok, input string tag, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=0x%0h exp=0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // behavioural reference model, stepped at each rising edge
    int        m_st = 0;
    int        m_pre = 0;
    bit        m_en = 0;
    bit [1:0]  m_pwr = 0;
    bit [1:0]  m_dsel = 0;
    bit [15:0] m_cnt = 0;
    bit        m_req = 0;
    bit        m_flag = 0;
    bit        m_applied = 0;
    logic [31:0] m_stat;

    function automatic int ratio_of(input bit [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 64;
            2'd2: return 4096;
            default: return 262144;
        endcase
    endfunction

    always @(posedge clk) begin
        if (por || rst) begin
            m_st = 0; m_en = 0; m_pwr = 0; m_dsel = 0; m_cnt = 0; m_pre = 0; m_req = 0;
            if (por) m_flag = 0;
        end else begin
            m_applied = 0;
            m_req = 0;
            if (we) begin
                if (m_st == 0) begin
                    m_st = (addr == 4'd0 && wdata == 32'h00BE0000) ? 1 : 0;
                end else begin
                    m_st = 0;
                    if (addr == 4'd0 && wdata[23:16] == 8'hDC) begin
                        m_applied = 1;
                        m_en = wdata[31];
                        m_pwr = wdata[27:26];
                        m_dsel = wdata[25:24];
                        m_cnt = wdata[15:0];
                        m_pre = 0;
                    end
                end
            end
            if (!m_applied && m_en) begin
                if (m_pre == ratio_of(m_dsel) - 1) begin
                    m_pre = 0;
                    if (m_cnt == 0) begin
                        m_req = 1; m_flag = 1; m_en = 0;
                    end else begin
                        m_cnt = m_cnt - 1;
                    end
                end else begin
                    m_pre = m_pre + 1;
                end
            end
        end
        #5;
        m_stat = (addr == 4'd8) ? {m_en, 3'b000, m_pwr, m_dsel, 8'h00, m_cnt} : 32'h0;
        check(rdata === m_stat, "R6 model status", rdata, m_stat);
        check(req === m_req, "R7 model request", req, m_req);
        check(flag === m_flag, "R8 model flag", flag, m_flag);
        check(code === (m_flag ? 3'd2 : 3'd0), "R8 model code", code, m_flag ? 2 : 0);
    end

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        #1;
        we = 1'b0; addr = 4'd8; wdata = '0;
        #2;
    endtask

    task automatic kick(input logic [31:0] d);
        bus_wr(4'd0, 32'h00BE0000);
        bus_wr(4'd0, d);
    endtask

    task automatic wait_req(output int n, input int limit);
        n = 0;
        while (req !== 1'b1 && n < limit) begin
            @(posedge clk);
            #5;
            n++;
        end
    endtask

    initial begin
        #(CLK_PER * WD_CYCLES);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0; por = 1'b0;
        #1;
        // R1 reset state
        check(rdata == 32'h0, "R1 status after reset", rdata, 0);
        check(req == 1'b0, "R1 request after reset", req, 0);
        check(flag == 1'b0 && code == 3'd0, "R1 flag after reset", flag, 0);

        // R2 configure en, power 3, div 0, reload 5
        kick(32'h8CDC0005);
        check(rdata == 32'h8C000005, "R2 config loaded", rdata, 32'h8C000005);
        // R7 expiry after (5+1)*1 edges
        wait_req(n, 100);
        check(n == 6, "R7 expiry cycle div0", n, 6);
        check(rdata == 32'h0C000000, "R7 enable cleared", rdata, 32'h0C000000);
        check(flag == 1'b1 && code == 3'd2, "R8 flag set", code, 2);
        @(posedge clk); #5;
        check(req == 1'b0, "R7 request one cycle", req, 0);

        // R1 / R8: ordinary reset keeps flag, power-on reset clears it
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check(flag == 1'b1 && code == 3'd2, "R8 flag survives rst", flag, 1);
        check(rdata == 32'h0, "R1 status after rst", rdata, 0);
        @(negedge clk); por = 1'b1;
        @(negedge clk); por = 1'b0; #1;
        check(flag == 1'b0 && code == 3'd0, "R1 por clears flag", flag, 0);

        // R3 ignored writes
        bus_wr(4'd0, 32'h80DC1234);
        check(rdata == 32'h0, "R3 config without key", rdata, 0);
        kick(32'h80DC0007);
        check(rdata == 32'h80000007, "R2 valid config", rdata, 32'h80000007);
        kick(32'h00DC0000);
        check(rdata == 32'h0, "R4 all-zero config turns off", rdata, 0);
        bus_wr(4'd0, 32'h00BE0000);
        bus_wr(4'd8, 32'h80DC0009);
        bus_wr(4'd0, 32'h80DC0009);
        check(rdata == 32'h0, "R3 status write breaks key", rdata, 0);
        bus_wr(4'd0, 32'h00BE0001);
        bus_wr(4'd0, 32'h80DC0009);
        check(rdata == 32'h0, "R3 bad opening word", rdata, 0);
        bus_wr(4'd0, 32'h00BE0000);
        bus_wr(4'd0, 32'h00BE0000);
        bus_wr(4'd0, 32'h80DC0009);
        check(rdata == 32'h0, "R3 repeated opening word", rdata, 0);
        bus_wr(4'd0, 32'h00BE0000);
        bus_wr(4'd0, 32'h80AB0009);
        bus_wr(4'd0, 32'h80DC0009);
        check(rdata == 32'h0, "R3 wrong config key", rdata, 0);
        bus_wr(4'd8, 32'hFFFFFFFF);
        check(rdata == 32'h0, "R3 status is read-only", rdata, 0);

        // R4 disabled config holds reload
        kick(32'h80DC0064);
        repeat (10) @(posedge clk);
        #3;
        check(rdata == 32'h8000005A, "R5 div0 counts each cycle", rdata, 32'h8000005A);
        kick(32'h00DC0030);
        repeat (100) @(posedge clk);
        #3;
        check(rdata == 32'h00000030, "R4 count holds when off", rdata, 32'h30);
        check(flag == 1'b0, "R4 no expiry when off", flag, 0);

        // R6 other offsets read zero
        @(negedge clk); addr = 4'd0; #1;
        check(rdata == 32'h0, "R6 offset 0 reads zero", rdata, 0);
        addr = 4'd4; #1;
        check(rdata == 32'h0, "R6 offset 4 reads zero", rdata, 0);
        addr = 4'd8; #1;
        check(rdata == 32'h00000030, "R6 offset 8 reads status", rdata, 32'h30);

        // R5 divider ratios
        kick(32'h81DC0003);
        wait_req(n, 1000);
        check(n == 256, "R5 expiry cycle div1", n, 256);
        kick(32'h82DC0002);
        wait_req(n, 20000);
        check(n == 12288, "R5 expiry cycle div2", n, 12288);
        kick(32'h83DC0001);
        repeat (5000) @(posedge clk);
        #3;
        check(rdata == 32'h83000001, "R5 div3 no step within 5000", rdata, 32'h83000001);
        kick(32'h00DC0000);

        // R9 keep-alive
        kick(32'h80DC0014);
        for (int k = 0; k < 8; k++) begin
            repeat (10) @(posedge clk);
            kick(32'h80DC0014);
            check(rdata == 32'h80000014 && req == 1'b0, "R9 kick reloads", rdata, 32'h80000014);
        end
        wait_req(n, 100);
        check(n == 21, "R9 expiry after kicks stop", n, 21);

        repeat (5) @(posedge clk);
        #6;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule